// File: doc/BRIEF.md
# Slotted Load-Modulation Frame Transmitter

This block sends tag-to-reader replies as on/off keying of a subcarrier in fixed bit slots. It does not drive the analog side. It only produces a modulate-enable level that the subcarrier generator gates on. All slot times come from a shared tick counter (`nowStamp`) and a reference stamp (`refStamp`). The reference stamp marks the end of the last frame the reader sent. Slot boundaries are computed by adding fixed tick counts to this reference. They are never measured from the moment a bit actually started, so a late start does not push later slots back.

There are two kinds of request. A data frame carries 1 to 16 bits. Each bit is XORed with one bit of an external keystream before it is sent. An acknowledge is a single unscrambled one bit, sent after a much longer gap. The keystream generator lives outside the block. The block steps it with a one-cycle strobe and reads its current output bit. During the waiting gap, the block steps the keystream a fixed number of times so that it is aligned when the first slot begins.

Top module: `slotFrameTx`

## Requirements
- R1: A data frame's first slot begins when `nowStamp` reaches `refStamp + 70`, and `modOut` stays low before that point.
- R2: Every slot lasts 21 ticks. Slot k of a frame spans ticks `ref + gap + 21k` to `ref + gap + 21(k+1)`, with no drift from one slot to the next.
- R3: A data frame sends bit 0 of `reqData` first. For slot k, `modOut` equals `reqData[k]` XOR `ksBit`, where `ksBit` is sampled at the start of that slot. A value of 1 means the subcarrier is on.
- R4: For a data frame, `ksStep` pulses exactly twice before the first slot, and once at the end of every slot. A frame of L bits therefore gives L+2 pulses in total.
- R5: When `reqIsAck` is 1, the block sends a single slot that starts at `refStamp + 758`. In that slot `modOut` is 1 whatever `ksBit` is. `ksStep` pulses 35 times before the slot and once after it.
- R6: Between two consecutive slots that both carry a 1, `modOut` does not drop low, not even for one cycle.
- R7: `modOut` goes low at the end of the last slot. `done` pulses high for exactly one cycle per frame, in the same cycle that `busy` falls.
- R8: `busy` rises in the cycle after a request is accepted and stays high until the subcarrier is switched off.
- R9: A request made while `busy` is high is ignored. It changes neither the frame in progress nor anything after it.
- R10: After reset, `modOut`, `busy`, `done` and `ksStep` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nowStamp | input | 16 | Free-running tick count of the subcarrier-rate timer |
| refStamp | input | 16 | Tick stamp of the end of the last reader frame, taken with the request |
| reqValid | input | 1 | Request strobe, accepted only while idle |
| reqIsAck | input | 1 | 1 = acknowledge, 0 = scrambled data frame |
| reqData | input | 16 | Frame payload, bit 0 sent first |
| reqLen | input | 5 | Data frame length in bits, 1 to 16 |
| ksBit | input | 1 | Current keystream output bit |
| ksStep | output | 1 | One-cycle strobe that advances the keystream |
| modOut | output | 1 | Subcarrier modulate enable |
| busy | output | 1 | High while a frame is pending or on air |
| done | output | 1 | One-cycle pulse when the subcarrier is switched off |

## Verification
A wrong slot target, such as one re-based on the actual bit start, moves the slot edges. It shows on `modOut` at the next slot boundary and gets worse with every bit, so long frames expose it within a few slots. A wrong pre-advance count, or a keystream step at the wrong time, shifts the scramble pattern by one position. That makes `modOut` differ from the expected XOR in roughly half the slots of the frame, and it also changes the `ksStep` pulse count that is compared at the first slot and at the end of the frame. A stuck or early-clearing `busy` shows either as a second frame started by an ignored request or as a missing `done` pulse when the frame ends.

// File: rtl/slotFrameTxPkg.sv
package slotFrameTxPkg;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch a new request
    logic preStep;  // count one gap keystream step
    logic arm;      // open the next slot
    logic endBit;   // close the current slot
  } txStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_LOAD = 2'd2,
    ST_SLOT = 2'd3
  } txStateT;

endpackage

// File: rtl/slotFrameTxData.sv
module slotFrameTxData
  import slotFrameTxPkg::*;
#(
  parameter int TS_W       = 16,
  parameter int DATA_W     = 16,
  parameter int LEN_W      = 5,
  parameter int SLOT_TICKS = 21,
  parameter int DATA_GAP   = 70,
  parameter int ACK_GAP    = 758
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobeT          strb,
  input  logic              reqIsAck,
  input  logic [DATA_W-1:0] reqData,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [TS_W-1:0]   refStamp,
  input  logic [TS_W-1:0]   nowStamp,
  input  logic              ksBit,
  output logic              modOut,
  output logic              preZero,
  output logic              reached,
  output logic              lastBit
);

  localparam int PRE_DATA = DATA_GAP / SLOT_TICKS - 1;
  localparam int PRE_ACK  = ACK_GAP / SLOT_TICKS - 1;
  localparam int PRE_MAX  = (PRE_ACK > PRE_DATA) ? PRE_ACK : PRE_DATA;
  localparam int PRE_W    = $clog2(PRE_MAX + 1);

  localparam logic [TS_W-1:0]  SLOT_T   = TS_W'(SLOT_TICKS);
  localparam logic [TS_W-1:0]  GAP_DATA = TS_W'(DATA_GAP);
  localparam logic [TS_W-1:0]  GAP_ACK  = TS_W'(ACK_GAP);
  localparam logic [PRE_W-1:0] PRE_D    = PRE_W'(PRE_DATA);
  localparam logic [PRE_W-1:0] PRE_A    = PRE_W'(PRE_ACK);
  localparam logic [LEN_W-1:0] ONE_LEN  = LEN_W'(1);

  logic [TS_W-1:0]   target;
  logic [TS_W-1:0]   diff;
  logic [PRE_W-1:0]  preCnt;
  logic [DATA_W-1:0] dataSr;
  logic [LEN_W-1:0]  remain;
  logic              isAck;

  // wrap-safe "now is at or past target"
  assign diff    = nowStamp - target;
  assign reached = ~diff[TS_W-1];
  assign preZero = (preCnt == '0);
  assign lastBit = (remain <= ONE_LEN);

  // absolute slot target: advanced by whole slots, never re-based
  always_ff @(posedge clk) begin
    if (!rstN) begin
      target <= '0;
    end else if (strb.load) begin
      target <= refStamp + (reqIsAck ? GAP_ACK : GAP_DATA);
    end else if (strb.arm) begin
      target <= target + SLOT_T;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (strb.load) begin
      preCnt <= reqIsAck ? PRE_A : PRE_D;
    end else if (strb.preStep) begin
      preCnt <= preCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataSr <= '0;
      remain <= '0;
      isAck  <= 1'b0;
    end else if (strb.load) begin
      dataSr <= reqData;
      isAck  <= reqIsAck;
      remain <= (reqIsAck || reqLen == '0) ? ONE_LEN : reqLen;
    end else if (strb.endBit) begin
      dataSr <= dataSr >> 1;
      remain <= remain - 1'b1;
    end
  end

  // modulate enable is only changed at slot open and after the final slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modOut <= 1'b0;
    end else if (strb.load) begin
      modOut <= 1'b0;
    end else if (strb.arm) begin
      modOut <= isAck ? 1'b1 : (dataSr[0] ^ ksBit);
    end else if (strb.endBit && lastBit) begin
      modOut <= 1'b0;
    end
  end

endmodule

// File: rtl/slotFrameTxCtrl.sv
module slotFrameTxCtrl
  import slotFrameTxPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     preZero,
  input  logic     reached,
  input  logic     lastBit,
  output txStrobeT strb,
  output logic     ksStep,
  output logic     busy,
  output logic     done
);

  txStateT state, stateNext;
  logic    finish;

  always_comb begin
    strb      = '0;
    ksStep    = 1'b0;
    finish    = 1'b0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strb.load = 1'b1;
          stateNext = ST_GAP;
        end
      end
      ST_GAP: begin
        if (!preZero) begin
          strb.preStep = 1'b1;
          ksStep       = 1'b1;
        end else if (reached) begin
          stateNext = ST_LOAD;
        end
      end
      ST_LOAD: begin
        strb.arm  = 1'b1;
        stateNext = ST_SLOT;
      end
      ST_SLOT: begin
        if (reached) begin
          strb.endBit = 1'b1;
          ksStep      = 1'b1;
          if (lastBit) begin
            finish    = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            stateNext = ST_LOAD;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= finish;
      if (strb.load) begin
        busy <= 1'b1;
      end else if (finish) begin
        busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/slotFrameTx.sv
module slotFrameTx
  import slotFrameTxPkg::*;
#(
  parameter int TS_W       = 16,
  parameter int DATA_W     = 16,
  parameter int LEN_W      = 5,
  parameter int SLOT_TICKS = 21,
  parameter int DATA_GAP   = 70,
  parameter int ACK_GAP    = 758
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TS_W-1:0]   nowStamp,
  input  logic [TS_W-1:0]   refStamp,
  input  logic              reqValid,
  input  logic              reqIsAck,
  input  logic [DATA_W-1:0] reqData,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              ksBit,
  output logic              ksStep,
  output logic              modOut,
  output logic              busy,
  output logic              done
);

  txStrobeT strb;
  logic     preZero;
  logic     reached;
  logic     lastBit;

  slotFrameTxCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .preZero  (preZero),
    .reached  (reached),
    .lastBit  (lastBit),
    .strb     (strb),
    .ksStep   (ksStep),
    .busy     (busy),
    .done     (done)
  );

  slotFrameTxData #(
    .TS_W       (TS_W),
    .DATA_W     (DATA_W),
    .LEN_W      (LEN_W),
    .SLOT_TICKS (SLOT_TICKS),
    .DATA_GAP   (DATA_GAP),
    .ACK_GAP    (ACK_GAP)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqIsAck (reqIsAck),
    .reqData  (reqData),
    .reqLen   (reqLen),
    .refStamp (refStamp),
    .nowStamp (nowStamp),
    .ksBit    (ksBit),
    .modOut   (modOut),
    .preZero  (preZero),
    .reached  (reached),
    .lastBit  (lastBit)
  );

endmodule

// File: rtl/slotFrameTxChk.sv
module slotFrameTxChk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic ksStep,
  input logic modOut,
  input logic busy,
  input logic done
);

  // R7: done marks the cycle in which busy has just dropped
  p_done_at_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R7: done is a single-cycle pulse
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: busy only ends together with a done pulse
  p_busy_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R8: subcarrier never enabled outside a busy period
  p_mod_in_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    modOut |-> busy);

  // R4: keystream is only stepped while a frame is pending
  p_step_in_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    ksStep |-> busy);

  // R9: a request seen while busy does not end the busy period
  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && reqValid && !done) |=> (busy || done));

endmodule

bind slotFrameTx slotFrameTxChk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .ksStep   (ksStep),
  .modOut   (modOut),
  .busy     (busy),
  .done     (done)
);

// File: tb/tb_slotFrameTx.sv
module tb_slotFrameTx;

  typedef struct {
    int          startT;
    int          len;
    logic [15:0] expBits;
    int          stepBase;
    int          doneBase;
    int          preSteps;
  } frameItemT;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] nowStamp;
  logic [15:0] refStamp = '0;
  logic        reqValid = 1'b0;
  logic        reqIsAck = 1'b0;
  logic [15:0] reqData = '0;
  logic [4:0]  reqLen = '0;
  logic        ksBit;
  logic        ksStep;
  logic        modOut;
  logic        busy;
  logic        done;

  int          nowCnt = 0;
  int          stepTotal = 0;
  int          doneTotal = 0;
  logic [6:0]  ksState = 7'h5B;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;
  frameItemT   sb[$];

  always #2 clk = ~clk;

  slotFrameTx dut (
    .clk      (clk),
    .rstN     (rstN),
    .nowStamp (nowStamp),
    .refStamp (refStamp),
    .reqValid (reqValid),
    .reqIsAck (reqIsAck),
    .reqData  (reqData),
    .reqLen   (reqLen),
    .ksBit    (ksBit),
    .ksStep   (ksStep),
    .modOut   (modOut),
    .busy     (busy),
    .done     (done)
  );

  function automatic logic [6:0] ksNext(logic [6:0] s);
    return {s[5:0], s[6] ^ s[5]};
  endfunction

  assign nowStamp = nowCnt[15:0];
  assign ksBit    = ksState[0];

  // tick timer and keystream model
  always @(posedge clk) begin
    nowCnt <= nowCnt + 1;
    if (rstN && ksStep) begin
      ksState   <= ksNext(ksState);
      stepTotal <= stepTotal + 1;
    end
    if (rstN && done) doneTotal <= doneTotal + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // driver: issue a request and push the expected frame
  task automatic sendFrame(input bit isAck, input logic [15:0] data,
                           input int len, input int refBack, input bit forceOnes);
    frameItemT   it;
    logic [6:0]  s;
    logic [15:0] d;
    int          gap;
    d   = data;
    gap = isAck ? 758 : 70;
    s   = ksState;
    s   = ksNext(ksNext(s));
    it.expBits = '0;
    if (isAck) begin
      it.expBits[0] = 1'b1;
    end else begin
      for (int k = 0; k < len; k++) begin
        if (forceOnes) d[k] = ~s[0];
        it.expBits[k] = d[k] ^ s[0];
        s = ksNext(s);
      end
    end
    it.startT   = nowCnt - refBack + gap;
    it.len      = isAck ? 1 : len;
    it.stepBase = stepTotal;
    it.doneBase = doneTotal;
    it.preSteps = isAck ? 35 : 2;
    refStamp = 16'(nowCnt - refBack);
    reqIsAck = isAck;
    reqData  = d;
    reqLen   = 5'(len);
    reqValid = 1'b1;
    sb.push_back(it);
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy == 1'b1, "R8 busy after accept", busy, 1);
  endtask

  task automatic waitIdle();
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic waitNow(input int v);
    while (nowCnt < v) @(negedge clk);
  endtask

  // monitor: compare each expected frame against the port activity
  initial begin
    frameItemT it;
    bit gapSeen;
    bit pairSeen;
    forever begin
      while (sb.size() == 0) @(negedge clk);
      it = sb[0];
      waitNow(it.startT - 2);
      chk(modOut == 1'b0, "R1 low before first slot", modOut, 0);
      chk(busy == 1'b1, "R8 busy during gap", busy, 1);
      chk(stepTotal - it.stepBase == it.preSteps, "R4/R5 gap keystream steps",
          stepTotal - it.stepBase, it.preSteps);
      gapSeen  = 1'b0;
      pairSeen = 1'b0;
      for (int k = 0; k < it.len; k++) begin
        while (nowCnt < it.startT + 21 * k + 10) begin
          @(negedge clk);
          if (k > 0 && it.expBits[k-1] && it.expBits[k]) begin
            pairSeen = 1'b1;
            if (!modOut) gapSeen = 1'b1;
          end
        end
        chk(modOut == it.expBits[k], "R2/R3/R5 slot value", modOut, it.expBits[k]);
      end
      if (pairSeen) chk(!gapSeen, "R6 no drop between ones", gapSeen, 0);
      waitNow(it.startT + 21 * it.len + 5);
      chk(modOut == 1'b0, "R7 off after last slot", modOut, 0);
      chk(busy == 1'b0, "R7 busy low after frame", busy, 0);
      chk(doneTotal - it.doneBase == 1, "R7 one done pulse",
          doneTotal - it.doneBase, 1);
      chk(stepTotal - it.stepBase == it.preSteps + it.len, "R4/R5 total steps",
          stepTotal - it.stepBase, it.preSteps + it.len);
      void'(sb.pop_front());
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(modOut == 1'b0, "R10 modOut reset", modOut, 0);
    chk(busy == 1'b0, "R10 busy reset", busy, 0);
    chk(done == 1'b0, "R10 done reset", done, 0);
    chk(ksStep == 1'b0, "R10 ksStep reset", ksStep, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    sendFrame(1'b0, 16'h00A5, 8, 3, 1'b0);   // R1 R3 basic frame
    waitIdle();
    sendFrame(1'b0, 16'h1234, 16, 0, 1'b0);  // R2 longest frame
    waitIdle();
    sendFrame(1'b0, 16'h0001, 1, 2, 1'b0);   // shortest frame
    waitIdle();
    sendFrame(1'b1, 16'h0000, 1, 1, 1'b0);   // R5 acknowledge
    waitIdle();
    sendFrame(1'b0, 16'h0000, 6, 0, 1'b1);   // R6 all slots on
    waitIdle();

    // R9: request while busy is ignored
    sendFrame(1'b0, 16'h0013, 5, 1, 1'b0);
    repeat (30) @(negedge clk);
    refStamp = nowStamp;
    reqIsAck = 1'b1;
    reqData  = 16'hFFFF;
    reqLen   = 5'd9;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    waitIdle();
    repeat (800) @(negedge clk);
    chk(busy == 1'b0, "R9 ignored request leaves busy low", busy, 0);
    chk(modOut == 1'b0, "R9 ignored request sends nothing", modOut, 0);

    sendFrame(1'b0, 16'h5A3C, 12, 0, 1'b0);  // accepted again after idle
    waitIdle();
    report();
  end

endmodule